// File: doc/BRIEF.md
# Tape Record Spacing Sequencer

This block paces a tape controller that skips over whole records without moving any data. It turns the transport's timing pulses into a character clock for the chosen recording density. The 200 characters-per-inch rate is made by letting through only every fourth pulse of the 800 clock. After a start pulse, the block raises GO and runs an acceleration delay. It then watches the read strobes to find where each record begins and ends.

Reverse travel meets the longitudinal check character first. That character's strobe only marks entry into the record and does not count as data. After the last strobe, three strobe-free character clocks produce a one-cycle record-over pulse. Each record-over restarts the deceleration delay. If the word count is not yet zero, record-over also requests a channel cycle that increments only the word count, and motion continues. If the word count is zero when record-over arrives, GO drops and the operation ends.

All inputs are single-cycle pulses or levels synchronous to `clk`. The transport pulses and read strobes are assumed to be synchronised upstream. `reverse` is held steady for the length of an operation.

Top module: `spc_sequencer`

## Requirements
- R1: With `density_sel` = 2'b00 every `clk800_pulse` gives one `char_clk` pulse one cycle later, and `clk556_pulse` gives none. With 2'b01 the roles of the two transport pulses swap.
- R2: With `density_sel` = 2'b10 only every fourth `clk800_pulse` gives a `char_clk` pulse one cycle later, and `clk556_pulse` gives none.
- R3: With `density_sel` = 2'b11 no transport pulse gives a `char_clk` pulse.
- R4: A change of `density_sel` restarts the divide-by-four count. A transport pulse in the cycle of the change gives no `char_clk` pulse and is not counted, so the first 200 cpi clock is the fourth 800 pulse after the change.
- R5: A `start` while GO is low sets `go` and `motion`, and holds `accel_busy` high for exactly ACCEL_CYCLES cycles. A `start` while GO is high changes nothing.
- R6: Read strobes and character clocks seen while `accel_busy` is high are ignored: `into_record` stays low and `record_over` is never asserted.
- R7: In forward motion (`reverse` = 0) the first strobe of a record sets both `into_record` and `data_present`.
- R8: In reverse motion the first strobe of a record sets `into_record` only. The second strobe sets `data_present`.
- R9: With `data_present` set, `record_over` pulses for one cycle, one cycle after the third `char_clk` pulse that follows the last strobe. Any strobe restarts that count. The pulse clears `into_record` and `data_present`.
- R10: A `record_over` while `wc_zero` is low gives a one-cycle `wc_xfer_req` in the next cycle, and `go` stays high.
- R11: A `record_over` while `wc_zero` is high clears `go` in the next cycle and raises no `wc_xfer_req`.
- R12: Each `record_over` starts the deceleration delay. `decel_busy` is high for exactly DECEL_CYCLES cycles starting the next cycle. `motion` is high whenever `go` or `decel_busy` is high.
- R13: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| density_sel | input | 2 | 00: 800 cpi, 01: 556 cpi, 10: 200 cpi, 11: no clock |
| clk800_pulse | input | 1 | One-cycle pulse per 800 clock from the transport |
| clk556_pulse | input | 1 | One-cycle pulse per 556 clock from the transport |
| read_strobe | input | 1 | One-cycle pulse per character read |
| start | input | 1 | Start pulse for a spacing operation |
| reverse | input | 1 | 1: reverse motion, 0: forward |
| wc_zero | input | 1 | Word count has reached zero |
| char_clk | output | 1 | Character clock pulse for the selected density |
| into_record | output | 1 | A strobe of the current record has been seen |
| data_present | output | 1 | A data character of the current record has been seen |
| record_over | output | 1 | One-cycle end-of-record pulse |
| wc_xfer_req | output | 1 | One-cycle request for a word-count-only channel cycle |
| accel_busy | output | 1 | Acceleration delay running |
| decel_busy | output | 1 | Deceleration delay running |
| go | output | 1 | Operation in progress |
| motion | output | 1 | Tape is moving (GO or deceleration) |

## Verification
The character clock is tried with all four density codes, feeding both transport pulses to each. This separates a wrong pass-through from a wrong divide ratio. A density switch made in the same cycle as an 800 pulse shows whether the divider restarts and whether the pulse in the switch cycle is dropped.

Record spacing is driven as a forward record whose strobes are broken up by character clocks. A strobe that arrives after two quiet clocks shows that the end-of-record count restarts rather than carrying over. A strobe and a second start during acceleration show that both are ignored.

A two-record forward run, first with the word count non-zero and then zero, separates the transfer path from the stop path. A reverse record shows that the leading strobe is kept out of data-present.

// File: rtl/spc_pkg.sv
// Shared types and constants for the record spacing sequencer.
package spc_pkg;

    // Density select encoding; the character clock source depends on it.
    typedef enum logic [1:0] {
        DEN_800 = 2'b00,
        DEN_556 = 2'b01,
        DEN_200 = 2'b10,
        DEN_OFF = 2'b11
    } density_e;

    // 800 pulses per 200 cpi character.
    localparam int unsigned DIV_LOW_DENSITY = 4;

    // Strobe-free character clocks from the last strobe to record-over.
    localparam int unsigned EOR_CLOCKS = 3;

endpackage

// File: rtl/spc_char_clock.sv
// Character clock generator.
// Picks the transport pulse that matches the selected density, or divides
// the 800 pulse for the low density. Output is registered: one cycle after
// the transport pulse. Assumes transport pulses are one cycle wide and
// synchronous to clk. A change of selection restarts the divider and
// suppresses output for the change cycle.
module spc_char_clock
    import spc_pkg::*;
#(
    parameter int unsigned DIV = DIV_LOW_DENSITY
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] density_sel,
    input  logic       p800,
    input  logic       p556,
    output logic       char_clk
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    density_e      sel_now;
    density_e      sel_q;
    logic [DW-1:0] div_cnt;
    logic          sel_same;
    logic          clk_next;

    assign sel_now  = density_e'(density_sel);
    assign sel_same = (sel_now == sel_q);

    // Select the pulse source for the current density.
    always_comb begin
        unique case (sel_now)
            DEN_800: clk_next = p800;
            DEN_556: clk_next = p556;
            DEN_200: clk_next = p800 && (div_cnt == DIV_LAST);
            default: clk_next = 1'b0;
        endcase
        clk_next = clk_next && sel_same;
    end

    // Track the selection and count 800 pulses modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= DEN_800;
            div_cnt <= '0;
        end else begin
            sel_q <= sel_now;
            if (!sel_same) begin
                div_cnt <= '0;
            end else if (p800) begin
                div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
            end
        end
    end

    // Register the character clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_clk <= 1'b0;
        end else begin
            char_clk <= clk_next;
        end
    end

endmodule

// File: rtl/spc_delay_timer.sv
// Reloadable down-counter for the motion delays.
// busy rises at the edge that samples load and stays high for CYCLES cycles.
// A load while busy restarts the full delay. Assumes CYCLES >= 1.
module spc_delay_timer #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Load the delay, or count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_INIT;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/spc_record_tracker.sv
// Record boundary tracker.
// Marks entry into a record and the presence of data from read strobes.
// In reverse, the first strobe is the check character and is not data.
// Then it counts strobe-free character clocks to find end-of-record.
// All state is cleared while enable is low (idle or accelerating).
// Assumes reverse is steady during an operation.
module spc_record_tracker
    import spc_pkg::*;
#(
    parameter int unsigned STAGES = EOR_CLOCKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic reverse,
    input  logic strobe,
    input  logic char_clk,
    output logic into_record,
    output logic data_present,
    output logic record_over
);
    localparam int unsigned SW = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [SW-1:0] STAGE_LAST = SW'(STAGES - 1);

    logic [SW-1:0] eor_stage;

    // Follow strobes and character clocks through one record.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            into_record  <= 1'b0;
            data_present <= 1'b0;
            eor_stage    <= '0;
            record_over  <= 1'b0;
        end else begin
            record_over <= 1'b0;
            if (strobe) begin
                eor_stage <= '0;
                if (!into_record) begin
                    into_record  <= 1'b1;
                    data_present <= !reverse;
                end else begin
                    data_present <= 1'b1;
                end
            end else if (char_clk && data_present) begin
                if (eor_stage == STAGE_LAST) begin
                    record_over  <= 1'b1;
                    into_record  <= 1'b0;
                    data_present <= 1'b0;
                    eor_stage    <= '0;
                end else begin
                    eor_stage <= eor_stage + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spc_sequencer.sv
// Tape record spacing sequencer (top).
// Holds GO, runs the acceleration and deceleration delays, and gates the
// record tracker until acceleration has finished. On each record-over it
// either requests a word-count-only channel cycle (count not zero) or ends
// the operation (count zero). Assumes wc_zero comes from the channel and
// is valid when record_over is high.
module spc_sequencer
    import spc_pkg::*;
#(
    parameter int unsigned ACCEL_CYCLES = 8,
    parameter int unsigned DECEL_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] density_sel,
    input  logic       clk800_pulse,
    input  logic       clk556_pulse,
    input  logic       read_strobe,
    input  logic       start,
    input  logic       reverse,
    input  logic       wc_zero,
    output logic       char_clk,
    output logic       into_record,
    output logic       data_present,
    output logic       record_over,
    output logic       wc_xfer_req,
    output logic       accel_busy,
    output logic       decel_busy,
    output logic       go,
    output logic       motion
);
    logic start_ok;
    logic monitor;

    assign start_ok = start && !go;
    assign monitor  = go && !accel_busy;
    assign motion   = go || decel_busy;

    spc_char_clock #(
        .DIV(DIV_LOW_DENSITY)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .density_sel(density_sel),
        .p800       (clk800_pulse),
        .p556       (clk556_pulse),
        .char_clk   (char_clk)
    );

    spc_delay_timer #(
        .CYCLES(ACCEL_CYCLES)
    ) u_accel (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start_ok),
        .busy (accel_busy)
    );

    spc_delay_timer #(
        .CYCLES(DECEL_CYCLES)
    ) u_decel (
        .clk  (clk),
        .rst_n(rst_n),
        .load (record_over),
        .busy (decel_busy)
    );

    spc_record_tracker #(
        .STAGES(EOR_CLOCKS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (monitor),
        .reverse     (reverse),
        .strobe      (read_strobe),
        .char_clk    (char_clk),
        .into_record (into_record),
        .data_present(data_present),
        .record_over (record_over)
    );

    // Raise GO on an accepted start, drop it on the final record-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go <= 1'b0;
        end else if (start_ok) begin
            go <= 1'b1;
        end else if (record_over && wc_zero) begin
            go <= 1'b0;
        end
    end

    // Request a word-count-only channel cycle per record passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_xfer_req <= 1'b0;
        end else begin
            wc_xfer_req <= record_over && !wc_zero;
        end
    end

endmodule

// File: rtl/spc_sequencer_chk.sv
// Property checker for spc_sequencer, bound to every instance.
module spc_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic wc_zero,
    input logic char_clk,
    input logic into_record,
    input logic data_present,
    input logic record_over,
    input logic wc_xfer_req,
    input logic accel_busy,
    input logic decel_busy,
    input logic go,
    input logic motion
);
    AST_START_ACCEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> accel_busy); // R5
    AST_NO_EOR_IN_ACCEL: assert property (@(posedge clk) disable iff (!rst_n)
        accel_busy |-> !record_over); // R6
    AST_DATA_IN_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        data_present |-> into_record); // R7
    AST_EOR_AFTER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        record_over |-> ($past(char_clk) && $past(data_present))); // R9
    AST_XFER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wc_xfer_req |-> ($past(record_over) && !$past(wc_zero))); // R10
    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wc_xfer_req |=> !wc_xfer_req); // R10
    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> ($past(record_over) && $past(wc_zero))); // R11
    AST_DECEL_START: assert property (@(posedge clk) disable iff (!rst_n)
        record_over |=> decel_busy); // R12
    AST_MOTION_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (go || decel_busy) |-> motion); // R12
endmodule

bind spc_sequencer spc_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wc_zero     (wc_zero),
    .char_clk    (char_clk),
    .into_record (into_record),
    .data_present(data_present),
    .record_over (record_over),
    .wc_xfer_req (wc_xfer_req),
    .accel_busy  (accel_busy),
    .decel_busy  (decel_busy),
    .go          (go),
    .motion      (motion)
);

// File: tb/tb_spc_sequencer.sv
// Directed bench for spc_sequencer: one task per scenario.
module tb_spc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int ACC = 8;
    localparam int DEC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] density_sel = 2'b00;
    logic       clk800_pulse = 1'b0;
    logic       clk556_pulse = 1'b0;
    logic       read_strobe = 1'b0;
    logic       start = 1'b0;
    logic       reverse = 1'b0;
    logic       wc_zero = 1'b0;
    logic       char_clk, into_record, data_present, record_over;
    logic       wc_xfer_req, accel_busy, decel_busy, go, motion;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spc_sequencer #(.ACCEL_CYCLES(ACC), .DECEL_CYCLES(DEC)) dut (
        .clk(clk), .rst_n(rst_n), .density_sel(density_sel),
        .clk800_pulse(clk800_pulse), .clk556_pulse(clk556_pulse),
        .read_strobe(read_strobe), .start(start), .reverse(reverse),
        .wc_zero(wc_zero), .char_clk(char_clk), .into_record(into_record),
        .data_present(data_present), .record_over(record_over),
        .wc_xfer_req(wc_xfer_req), .accel_busy(accel_busy),
        .decel_busy(decel_busy), .go(go), .motion(motion)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs; returns at the next falling edge.
    task automatic step(input logic p8, input logic p5, input logic stb, input logic st);
        clk800_pulse = p8; clk556_pulse = p5; read_strobe = stb; start = st;
        @(negedge clk);
        clk800_pulse = 1'b0; clk556_pulse = 1'b0; read_strobe = 1'b0; start = 1'b0;
    endtask

    task automatic set_density(input logic [1:0] d);
        density_sel = d;
        step(0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R13 char_clk", char_clk, 0);
        chk("R13 go", go, 0);
        chk("R13 motion", motion, 0);
        chk("R13 busy", accel_busy | decel_busy, 0);
        chk("R13 record", into_record | data_present | record_over | wc_xfer_req, 0);
    endtask

    task automatic t_pass_through();
        set_density(2'b00);
        step(1, 0, 0, 0); chk("R1 800 passes", char_clk, 1);
        step(0, 0, 0, 0); chk("R1 one cycle", char_clk, 0);
        step(0, 1, 0, 0); chk("R1 556 blocked at 800", char_clk, 0);
        set_density(2'b01);
        step(0, 1, 0, 0); chk("R1 556 passes", char_clk, 1);
        step(1, 0, 0, 0); chk("R1 800 blocked at 556", char_clk, 0);
    endtask

    task automatic t_divide();
        int seen;
        set_density(2'b10);
        seen = 0;
        for (int i = 1; i <= 8; i++) begin
            step(1, 0, 0, 0);
            chk($sformatf("R2 pulse %0d", i), char_clk, (i % 4 == 0) ? 1 : 0);
            seen += char_clk;
            step(0, 0, 0, 0);
        end
        chk("R2 count of clocks", seen, 2);
        step(0, 1, 0, 0); chk("R2 556 blocked", char_clk, 0);
    endtask

    task automatic t_restart();
        set_density(2'b10);
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        density_sel = 2'b00;
        step(1, 0, 0, 0); chk("R4 change cycle suppressed", char_clk, 0);
        density_sel = 2'b10;
        step(1, 0, 0, 0); chk("R4 change back suppressed", char_clk, 0);
        for (int i = 1; i <= 4; i++) begin
            step(1, 0, 0, 0);
            chk($sformatf("R4 pulse %0d after change", i), char_clk, (i == 4) ? 1 : 0);
        end
    endtask

    task automatic t_off();
        int seen = 0;
        set_density(2'b11);
        for (int i = 0; i < 6; i++) begin
            step(1, i % 2, 0, 0);
            seen += char_clk;
        end
        chk("R3 no clocks", seen, 0);
    endtask

    // Start an operation and measure the acceleration window.
    task automatic start_op(input string tag, input bit stray);
        int busy_cnt = 1;
        step(0, 0, 0, 1);
        chk({tag, " R5 go"}, go, 1);
        chk({tag, " R5 motion"}, motion, 1);
        for (int i = 1; i < 4 * ACC && accel_busy; i++) begin
            step(0, 0, stray && i == 1, stray && i == 3);
            if (stray && i == 1) chk({tag, " R6 strobe ignored"}, into_record, 0);
            if (accel_busy) busy_cnt++;
        end
        chk({tag, " R5 accel length"}, busy_cnt, ACC);
    endtask

    task automatic char_tick();
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    // Three strobe-free clocks; record-over after the last. Then check result.
    task automatic end_record(input string tag, input bit last);
        char_tick(); chk({tag, " R9 no eor at 1"}, record_over, 0);
        char_tick(); chk({tag, " R9 no eor at 2"}, record_over, 0);
        char_tick(); chk({tag, " R9 eor at 3"}, record_over, 1);
        chk({tag, " R9 clears into_record"}, into_record, 0);
        step(0, 0, 0, 0);
        chk({tag, " R9 single pulse"}, record_over, 0);
        if (!last) begin
            chk({tag, " R10 xfer"}, wc_xfer_req, 1);
            chk({tag, " R10 go held"}, go, 1);
        end else begin
            chk({tag, " R11 no xfer"}, wc_xfer_req, 0);
            chk({tag, " R11 go cleared"}, go, 0);
            chk({tag, " R12 motion in decel"}, motion, 1);
        end
    endtask

    task automatic t_forward();
        int dcnt;
        set_density(2'b00);
        reverse = 1'b0; wc_zero = 1'b0;
        start_op("fwd", 1'b1);
        step(0, 0, 1, 0);
        chk("R7 into_record", into_record, 1);
        chk("R7 data_present", data_present, 1);
        char_tick(); char_tick();
        step(0, 0, 1, 0);
        char_tick(); char_tick();
        chk("R9 strobe restarts count", record_over, 0);
        step(0, 0, 1, 0);
        end_record("fwd1", 1'b0);
        dcnt = 1;
        chk("R12 decel started", decel_busy, 1);
        for (int i = 0; i < 4 * DEC && decel_busy; i++) begin
            step(0, 0, 0, 0);
            if (i == 0) chk("R10 xfer one cycle", wc_xfer_req, 0);
            if (decel_busy) dcnt++;
        end
        chk("R12 decel length", dcnt, DEC);
        chk("R12 motion with go", motion, 1);
        wc_zero = 1'b1;
        step(0, 0, 1, 0);
        end_record("fwd2", 1'b1);
        repeat (DEC) step(0, 0, 0, 0);
        chk("R12 motion stops", motion, 0);
        wc_zero = 1'b0;
    endtask

    task automatic t_reverse();
        set_density(2'b00);
        reverse = 1'b1; wc_zero = 1'b1;
        start_op("rev", 1'b0);
        step(0, 0, 1, 0);
        chk("R8 check char into_record", into_record, 1);
        chk("R8 check char not data", data_present, 0);
        char_tick(); char_tick(); char_tick();
        chk("R8 no eor without data", record_over, 0);
        step(0, 0, 1, 0);
        chk("R8 second strobe data", data_present, 1);
        end_record("rev", 1'b1);
        reverse = 1'b0; wc_zero = 1'b0;
        repeat (DEC) step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass_through();
        t_divide();
        t_restart();
        t_off();
        t_forward();
        t_reverse();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule